// File: doc/BRIEF.md
# APB Requester Transfer Controller

This block sits between a simple command source and one APB completer. A command carries an address, a direction, write data, byte-lane write strobes and a protection code, and is offered with a valid/ready handshake. The controller turns each accepted command into one APB transfer. It drives the select, enable, address, direction, write data, strobe and protection lines. It samples the completer's ready, read data and error lines. When the transfer ends, it reports the result as a one-cycle done pulse together with the read data and an error flag.

The core is a three-state machine with the states IDLE, SETUP and ACCESS. It moves through these transitions:

- **IDLE→SETUP**: a command is accepted.
- **SETUP→ACCESS**: always taken after one cycle.
- **ACCESS→ACCESS**: a wait state, taken while the completer holds ready low.
- **ACCESS→IDLE**: the transfer completes and no command is waiting.
- **ACCESS→SETUP**: the transfer completes and a command is waiting. The next command is accepted in the completing cycle, so transfers chain with no idle gap.

Commands are accepted only in IDLE or in the completing ACCESS cycle.

Top module: `apb_xfer_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is asserted and right after it, `apb_sel`, `apb_enable` and `rsp_done` are 0 and `cmd_ready` is 1 (state IDLE).
- R2: A command accepted in IDLE produces, in the next cycle, the SETUP phase. In SETUP, `apb_sel`=1 and `apb_enable`=0, and `apb_addr`, `apb_write`, `apb_prot` and (for a write) `apb_wdata` and `apb_strb` equal the accepted command's fields.
- R3: SETUP lasts exactly one cycle and is always followed by ACCESS, where `apb_sel`=1 and `apb_enable`=1, whatever `apb_ready` shows during SETUP.
- R4: While `apb_ready` is 0 in ACCESS, the controller stays in ACCESS. Address, direction, write data, strobes and protection stay unchanged.
- R5: When `apb_ready` is 1 in ACCESS and `cmd_valid` is 0, the next cycle is IDLE (`apb_sel`=0, `apb_enable`=0).
- R6: When `apb_ready` is 1 in ACCESS and `cmd_valid` is 1, that command is accepted. The next cycle is its SETUP phase, with no IDLE cycle in between.
- R7: `cmd_ready` is 1 only in IDLE or in an ACCESS cycle with `apb_ready`=1. It is 0 in SETUP and in ACCESS wait cycles, and commands offered there are not taken.
- R8: `rsp_done` pulses high for exactly one cycle, in the cycle after each completing ACCESS cycle. `rsp_rdata` then holds `apb_rdata` as sampled in the completing cycle for a read, and 0 for a write.
- R9: `rsp_err` equals `apb_err` as sampled in the completing cycle (select, enable and ready all 1). Error values during SETUP or wait cycles have no effect.
- R10: For a read (`apb_write`=0), `apb_strb` is all zeros during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_addr | input | ADDR_W | Command address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | DATA_W | Write data |
| cmd_wstrb | input | DATA_W/8 | Byte-lane write strobes |
| cmd_prot | input | PROT_W | Protection code |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data (0 after a write) |
| rsp_err | output | 1 | Captured completer error |
| apb_sel | output | 1 | Completer select |
| apb_enable | output | 1 | Access phase strobe |
| apb_addr | output | ADDR_W | Bus address |
| apb_write | output | 1 | Bus direction |
| apb_wdata | output | DATA_W | Bus write data |
| apb_strb | output | DATA_W/8 | Bus write strobes |
| apb_prot | output | PROT_W | Bus protection code |
| apb_ready | input | 1 | Completer ready / wait-state control |
| apb_rdata | input | DATA_W | Completer read data |
| apb_err | input | 1 | Completer error |

## Verification
The bench sweeps wait-state counts of zero to three, with standalone and chained transfers, mixed directions and error patterns.

Each corner case it targets, and the failure it would expose:

- **Junk command during SETUP or wait cycles.** A design that accepted it would overwrite the address mid-transfer.
- **Ready raised during SETUP.** A design that tested ready there would skip ACCESS.
- **Error raised in wait cycles but not at completion.** A design that sampled the error too early would report false errors.
- **Chained command in the completing cycle.** A design that wrongly inserts an IDLE gap, or drops the chained command, shows up on the cycle after completion.
- **Read transfers.** A design that lets strobes through on reads, or returns bus data for writes, fails on those transfers.

// File: rtl/apbx_pkg.sv
package apbx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } apbx_state_e;

endpackage

// File: rtl/apbx_fsm.sv
module apbx_fsm
    import apbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        apb_ready,
    output apbx_state_e state_q,
    output logic        cmd_ready,
    output logic        accept,
    output logic        complete,
    output logic        sel,
    output logic        enable
);

    apbx_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                state_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (apb_ready) begin
                    state_d = cmd_valid ? ST_SETUP : ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs decoded from the registered state
    always_comb begin
        sel       = (state_q != ST_IDLE);
        enable    = (state_q == ST_ACCESS);
        complete  = (state_q == ST_ACCESS) && apb_ready;
        cmd_ready = (state_q == ST_IDLE) || complete;
        accept    = cmd_valid && cmd_ready;
    end

    a_r3_setup_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SETUP |=> state_q == ST_ACCESS);

    a_r4_wait_stays_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS && !apb_ready) |=> state_q == ST_ACCESS);

    a_r5_complete_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS && apb_ready && !cmd_valid) |=> state_q == ST_IDLE);

    a_r6_chain_to_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACCESS && apb_ready && cmd_valid) |=> state_q == ST_SETUP);

endmodule

// File: rtl/apbx_req_reg.sv
module apbx_req_reg #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PROT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic                in_write,
    input  logic [DATA_W-1:0]   in_wdata,
    input  logic [DATA_W/8-1:0] in_strb,
    input  logic [PROT_W-1:0]   in_prot,
    output logic [ADDR_W-1:0]   addr_q,
    output logic                write_q,
    output logic [DATA_W-1:0]   wdata_q,
    output logic [DATA_W/8-1:0] strb_q,
    output logic [PROT_W-1:0]   prot_q
);

    localparam int LANES = DATA_W / 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
            prot_q  <= '0;
        end else if (load) begin
            addr_q  <= in_addr;
            write_q <= in_write;
            wdata_q <= in_wdata;
            prot_q  <= in_prot;
        end
    end

    // per-lane strobe: a read never enables a lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                strb_q[g] <= 1'b0;
            end else if (load) begin
                strb_q[g] <= in_write & in_strb[g];
            end
        end
    end

    a_r10_read_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
        !write_q |-> strb_q == '0);

endmodule

// File: rtl/apbx_resp.sv
module apbx_resp #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              complete,
    input  logic              is_write,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_done <= complete;
            if (complete) begin
                rsp_rdata <= is_write ? '0 : bus_rdata;
                rsp_err   <= bus_err;
            end
        end
    end

    a_r9_err_from_completion: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> rsp_err == $past(bus_err));

    a_r8_write_returns_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && $past(is_write)) |-> rsp_rdata == '0);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(complete));

endmodule

// File: rtl/apb_xfer_ctrl.sv
module apb_xfer_ctrl
    import apbx_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PROT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                cmd_write,
    input  logic [DATA_W-1:0]   cmd_wdata,
    input  logic [DATA_W/8-1:0] cmd_wstrb,
    input  logic [PROT_W-1:0]   cmd_prot,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    output logic                apb_sel,
    output logic                apb_enable,
    output logic [ADDR_W-1:0]   apb_addr,
    output logic                apb_write,
    output logic [DATA_W-1:0]   apb_wdata,
    output logic [DATA_W/8-1:0] apb_strb,
    output logic [PROT_W-1:0]   apb_prot,
    input  logic                apb_ready,
    input  logic [DATA_W-1:0]   apb_rdata,
    input  logic                apb_err
);

    apbx_state_e state_q;
    logic        accept;
    logic        complete;

    apbx_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .apb_ready (apb_ready),
        .state_q   (state_q),
        .cmd_ready (cmd_ready),
        .accept    (accept),
        .complete  (complete),
        .sel       (apb_sel),
        .enable    (apb_enable)
    );

    apbx_req_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PROT_W (PROT_W)
    ) i_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .in_addr  (cmd_addr),
        .in_write (cmd_write),
        .in_wdata (cmd_wdata),
        .in_strb  (cmd_wstrb),
        .in_prot  (cmd_prot),
        .addr_q   (apb_addr),
        .write_q  (apb_write),
        .wdata_q  (apb_wdata),
        .strb_q   (apb_strb),
        .prot_q   (apb_prot)
    );

    apbx_resp #(
        .DATA_W (DATA_W)
    ) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .complete  (complete),
        .is_write  (apb_write),
        .bus_rdata (apb_rdata),
        .bus_err   (apb_err),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    a_r3_enable_within_sel: assert property (@(posedge clk) disable iff (!rst_n)
        apb_enable |-> apb_sel);

    a_r4_bus_stable_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && apb_enable && !apb_ready) |=>
            ($stable(apb_addr) && $stable(apb_write) && $stable(apb_wdata)
             && $stable(apb_strb) && $stable(apb_prot)));

    a_r7_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!apb_sel || (apb_enable && apb_ready)));

    a_r2_setup_has_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (accept) |=> (apb_sel && !apb_enable));

    a_r8_done_after_completion: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(apb_sel && apb_enable && apb_ready));

endmodule

// File: tb/test_apb_xfer_ctrl.sv
module test_apb_xfer_ctrl;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int SW = DW / 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_write = 1'b0;
    logic [DW-1:0] cmd_wdata = '0;
    logic [SW-1:0] cmd_wstrb = '0;
    logic [PW-1:0] cmd_prot = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;
    logic          apb_sel;
    logic          apb_enable;
    logic [AW-1:0] apb_addr;
    logic          apb_write;
    logic [DW-1:0] apb_wdata;
    logic [SW-1:0] apb_strb;
    logic [PW-1:0] apb_prot;
    logic          apb_ready = 1'b0;
    logic [DW-1:0] apb_rdata = '0;
    logic          apb_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    apb_xfer_ctrl #(
        .ADDR_W (AW),
        .DATA_W (DW),
        .PROT_W (PW)
    ) i_apb_xfer_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_addr   (cmd_addr),
        .cmd_write  (cmd_write),
        .cmd_wdata  (cmd_wdata),
        .cmd_wstrb  (cmd_wstrb),
        .cmd_prot   (cmd_prot),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .apb_sel    (apb_sel),
        .apb_enable (apb_enable),
        .apb_addr   (apb_addr),
        .apb_write  (apb_write),
        .apb_wdata  (apb_wdata),
        .apb_strb   (apb_strb),
        .apb_prot   (apb_prot),
        .apb_ready  (apb_ready),
        .apb_rdata  (apb_rdata),
        .apb_err    (apb_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [AW-1:0] f_addr(int i, int s);
        return AW'(((i * 13 + s * 5 + 1) * 4) & 12'hFFC);
    endfunction
    function automatic logic f_write(int i, int s);
        return ((i + s) % 2) == 0;
    endfunction
    function automatic logic [DW-1:0] f_wdata(int i, int s);
        return 32'hC0DE_0000 ^ (i * 32'h0011_0011) ^ (s * 32'h0101_0000);
    endfunction
    function automatic logic [SW-1:0] f_strb(int i, int s);
        return SW'((i + s) % 15 + 1);
    endfunction
    function automatic logic [PW-1:0] f_prot(int i, int s);
        return PW'((i + 2 * s) % 8);
    endfunction
    function automatic logic [DW-1:0] f_rdata(int i, int s);
        return ~f_wdata(i, s) ^ 32'h0000_005A;
    endfunction
    function automatic logic f_err(int i, int s);
        return ((i + s) % 3) == 1;
    endfunction

    task automatic drive_cmd(int i, int s);
        cmd_valid = 1'b1;
        cmd_addr  = f_addr(i, s);
        cmd_write = f_write(i, s);
        cmd_wdata = f_wdata(i, s);
        cmd_wstrb = f_strb(i, s);
        cmd_prot  = f_prot(i, s);
    endtask

    task automatic drive_junk();
        cmd_valid = 1'b1;
        cmd_addr  = 12'hFFF;
        cmd_write = 1'b1;
        cmd_wdata = 32'hDEAD_BEEF;
        cmd_wstrb = '1;
        cmd_prot  = '1;
    endtask

    task automatic check_bus(string tag, int i, int s);
        logic wr;
        wr = f_write(i, s);
        check({tag, " addr"}, 32'(apb_addr), 32'(f_addr(i, s)));
        check({tag, " write"}, 32'(apb_write), 32'(wr));
        check({tag, " prot"}, 32'(apb_prot), 32'(f_prot(i, s)));
        if (wr) begin
            check({tag, " wdata"}, apb_wdata, f_wdata(i, s));
            check({tag, " strb"}, 32'(apb_strb), 32'(f_strb(i, s)));
        end else begin
            check("R10 read strobes zero", 32'(apb_strb), 32'h0);
        end
    endtask

    task automatic run_seq(int wbase, bit b2b, int s);
        for (int i = 0; i < 4; i++) begin
            int   waits;
            logic wr;
            waits = (wbase + i) % 4;
            wr    = f_write(i, s);
            if (i == 0 || !b2b) begin
                drive_cmd(i, s);
                #1;
                check("R7 ready in idle", 32'(cmd_ready), 32'h1);
                tick();
            end
            // SETUP phase: junk command, ready and error high must be ignored
            drive_junk();
            apb_ready = 1'b1;
            apb_err   = 1'b1;
            #1;
            check("R2 setup sel", 32'(apb_sel), 32'h1);
            check("R2 setup enable low", 32'(apb_enable), 32'h0);
            check_bus("R2 setup", i, s);
            check("R7 not ready in setup", 32'(cmd_ready), 32'h0);
            tick();
            check("R3 access sel", 32'(apb_sel), 32'h1);
            check("R3 access enable", 32'(apb_enable), 32'h1);
            for (int k = 0; k < waits; k++) begin
                apb_ready = 1'b0;
                apb_err   = 1'b1;
                drive_junk();
                #1;
                check("R7 not ready in wait", 32'(cmd_ready), 32'h0);
                tick();
                check("R4 wait enable held", 32'(apb_enable), 32'h1);
                check("R4 wait sel held", 32'(apb_sel), 32'h1);
                check_bus("R4 wait stable", i, s);
            end
            // completing cycle
            apb_ready = 1'b1;
            apb_err   = f_err(i, s);
            apb_rdata = f_rdata(i, s);
            if (b2b && i < 3) begin
                drive_cmd(i + 1, s);
            end else begin
                cmd_valid = 1'b0;
            end
            #1;
            check("R7 ready on completion", 32'(cmd_ready), 32'h1);
            tick();
            apb_ready = 1'b0;
            apb_err   = 1'b0;
            apb_rdata = 32'h1234_5678;
            cmd_valid = 1'b0;
            check("R8 done pulse", 32'(rsp_done), 32'h1);
            check("R8 response data", rsp_rdata, wr ? 32'h0 : f_rdata(i, s));
            check("R9 response error", 32'(rsp_err), 32'(f_err(i, s)));
            if (b2b && i < 3) begin
                check("R6 chained setup sel", 32'(apb_sel), 32'h1);
                check("R6 chained setup enable", 32'(apb_enable), 32'h0);
            end else begin
                check("R5 idle sel", 32'(apb_sel), 32'h0);
                check("R5 idle enable", 32'(apb_enable), 32'h0);
                tick();
                check("R8 done single cycle", 32'(rsp_done), 32'h0);
                check("R5 still idle", 32'(apb_sel), 32'h0);
            end
        end
    endtask

    initial begin
        repeat (3) tick();
        check("R1 reset sel", 32'(apb_sel), 32'h0);
        check("R1 reset enable", 32'(apb_enable), 32'h0);
        check("R1 reset done", 32'(rsp_done), 32'h0);
        check("R1 reset ready", 32'(cmd_ready), 32'h1);
        rst_n = 1'b1;
        tick();
        check("R1 idle after reset", 32'(apb_sel), 32'h0);
        for (int w = 0; w < 4; w++) begin
            for (int b = 0; b < 2; b++) begin
                run_seq(w, b[0], w * 2 + b);
            end
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completed run");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule